// File: doc/BRIEF.md
# Pulse-Width Bit Line Encoder

This block turns a stream of single data bits into a serial line for a radio front end. Every bit takes one bit period, and its length in clock cycles is a programmable length value plus a fixed offset of six. The resulting bit rate is the clock frequency divided by that period. A one is sent as a high pulse at the start of the period, followed by low for the rest of it. A zero keeps the line low for the whole period.

Bits arrive over a valid/ready handshake. The length value is captured when each bit is accepted, so software can change it at any time and the change applies at the next bit boundary. While valid stays high, bits follow one another with no idle cycles between them. When nothing is pending, the line rests low and the busy flag drops.

Top module: `pw_line_encoder`

## Requirements
- R1: A bit period lasts exactly `bit_len_i + 6` clock cycles, counted from the cycle after acceptance. Consecutive bits start exactly one period apart.
- R2: For a one, the line is high for the first `floor((bit_len_i + 6) / 2) - 1` cycles of the period and low for the remaining cycles.
- R3: For a zero, the line is low for every cycle of the period.
- R4: The length value is sampled in the accepting cycle. Any change to `bit_len_i` during a bit does not alter that bit and only affects the next accepted bit.
- R5: `bit_ready_o` is high while idle and in the last cycle of a bit period, and low in every other cycle of a period.
- R6: While valid stays high, bits are sent back to back. When no bit is pending, `line_o` and `busy_o` are low.
- R7: During reset, `line_o` is low, `busy_o` is low and `bit_ready_o` is high.
- R8: `busy_o` is high from the cycle after acceptance through the last cycle of the bit.
- R9: `bit_len_i` is 8 bits wide. A value of 0 gives a 6-cycle period with 2 high cycles for a one. A value of 255 gives a 261-cycle period with 129 high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_len_i | input | 8 | Bit length value; period is this plus 6 |
| bit_valid_i | input | 1 | A data bit is offered |
| bit_data_i | input | 1 | Value of the offered bit |
| bit_ready_o | output | 1 | Encoder takes the offered bit at the next edge |
| line_o | output | 1 | Serial line toward the radio |
| busy_o | output | 1 | A bit period is in progress |

## Verification
The hardest case to reach is a length change that lands partway through a streamed bit while the next bit is already waiting. In that case the bit in flight must keep its captured period, and the waiting bit must pick up the new value exactly at the boundary. The bench sets up this case all the time: at the negative edge right after each acceptance, it loads the length input with the value for the following bit, or with a random value during idle gaps. It also runs long back-to-back streams and directed runs at the extreme lengths 0 and 255.

// File: rtl/pw_enc_pkg.sv
package pw_enc_pkg;
  // high clocks of a one: floor(period/2 - 1)
  function automatic int unsigned one_high_clocks(input int unsigned period);
    return period / 2 - 1;
  endfunction
endpackage

// File: rtl/pw_enc_period_cnt.sv
module pw_enc_period_cnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/pw_enc_pulse_gen.sv
module pw_enc_pulse_gen #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             data_i,
  input  logic [CNT_W-1:0] hi_len_i,
  output logic             line_o
);
  logic [CNT_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           hi_q <= '0;
    else if (load_i)       hi_q <= data_i ? hi_len_i : '0;
    else if (hi_q != '0)   hi_q <= hi_q - 1'b1;
  end

  assign line_o = (hi_q != '0);
endmodule

// File: rtl/pw_line_encoder.sv
module pw_line_encoder #(
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned BIT_OFS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] bit_len_i,
  input  logic             bit_valid_i,
  input  logic             bit_data_i,
  output logic             bit_ready_o,
  output logic             line_o,
  output logic             busy_o
);
  import pw_enc_pkg::*;

  localparam int unsigned MAX_PERIOD = (1 << LEN_W) - 1 + BIT_OFS;
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD + 1);

  logic             active_q;
  logic             last;
  logic             accept;
  logic [CNT_W-1:0] period_m1;
  logic [CNT_W-1:0] hi_len;

  assign period_m1 = CNT_W'(bit_len_i) + CNT_W'(BIT_OFS - 1);
  assign hi_len    = CNT_W'(one_high_clocks(32'(bit_len_i) + BIT_OFS));

  assign bit_ready_o = !active_q || last;
  assign accept      = bit_valid_i && bit_ready_o;
  assign busy_o      = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= 1'b0;
    else if (accept) active_q <= 1'b1;
    else if (last)   active_q <= 1'b0;
  end

  pw_enc_period_cnt #(.CNT_W(CNT_W)) period_cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (period_m1),
    .last_o     (last)
  );

  pw_enc_pulse_gen #(.CNT_W(CNT_W)) pulse_gen_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .data_i   (bit_data_i),
    .hi_len_i (hi_len),
    .line_o   (line_o)
  );
endmodule

// File: rtl/pw_line_encoder_chk.sv
module pw_line_encoder_chk #(
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned BIT_OFS = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LEN_W-1:0] bit_len_i,
  input logic             bit_valid_i,
  input logic             bit_data_i,
  input logic             bit_ready_o,
  input logic             line_o,
  input logic             busy_o
);
  localparam int unsigned CW = LEN_W + 2;

  logic          acc;
  logic [CW-1:0] since_q, exp_last_q, run_q, exp_hi_q;

  assign acc = bit_valid_i && bit_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q    <= '0;
      exp_last_q <= '0;
      exp_hi_q   <= '0;
      run_q      <= '0;
    end else begin
      if (acc) begin
        since_q    <= '0;
        exp_last_q <= CW'(bit_len_i) + CW'(BIT_OFS - 1);
        exp_hi_q   <= bit_data_i ? CW'((32'(bit_len_i) + BIT_OFS) / 2 - 1) : '0;
      end else if (busy_o) begin
        since_q <= since_q + 1'b1;
      end
      run_q <= line_o ? run_q + 1'b1 : '0;
    end
  end

  assert_period_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bit_ready_o) |-> (since_q == exp_last_q));
  assert_one_starts_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && bit_data_i) |=> line_o);
  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_o) |-> (run_q == exp_hi_q));
  assert_pulse_no_overrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> (run_q < exp_hi_q));
  assert_zero_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !bit_data_i) |=> !line_o);
  assert_ready_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> bit_ready_o);
  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_o);
  assert_rise_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_o) |-> $past(acc));
  assert_busy_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o);
  assert_busy_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_ready_o) |=> busy_o);
endmodule

bind pw_line_encoder pw_line_encoder_chk #(.LEN_W(LEN_W), .BIT_OFS(BIT_OFS)) chk_i (.*);

// File: tb/pw_line_encoder_tb_top.sv
`timescale 1ns/1ps
module pw_line_encoder_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] bit_len_i = '0;
  logic       bit_valid_i = 1'b0;
  logic       bit_data_i = 1'b0;
  logic       bit_ready_o, line_o, busy_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit rst_done = 1'b0;
  bit prev_line = 1'b0;

  typedef struct {bit ln; string tag;} exp_t;
  exp_t exp_q[$];
  int   rises[$];

  always #2.5 clk_i = ~clk_i;

  pw_line_encoder dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int hi_clocks(input int blr);
    return (blr + 6) / 2 - 1;
  endfunction

  task automatic push_bit(input bit d, input int blr);
    string tg;
    tg = (blr == 0 || blr == 255) ? "R9" : (d ? "R2" : "R3");
    for (int i = 0; i < blr + 6; i++) exp_q.push_back('{d && (i < hi_clocks(blr)), tg});
  endtask

  task automatic send(input bit d, input int blr);
    @(negedge clk_i);
    bit_len_i   = 8'(blr);
    bit_data_i  = d;
    bit_valid_i = 1'b1;
    while (!bit_ready_o) @(negedge clk_i);
    push_bit(d, blr);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    bit_len_i   = 8'($urandom);  // R4: stray length changes mid-bit
    for (int i = 1; i < n; i++) @(negedge clk_i);
  endtask

  task automatic drain();
    idle(1);
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  // monitor, sampled 1 ns after each rising edge
  initial forever begin
    exp_t e;
    @(posedge clk_i);
    #1;
    cyc++;
    if (!rst_done) continue;
    if (line_o && !prev_line) rises.push_back(cyc);
    prev_line = line_o;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      chk(e.tag, line_o, e.ln);
      chk("R8", busy_o, 1);
      chk("R5", bit_ready_o, exp_q.size() == 0);
    end else begin
      chk("R6", line_o, 0);
      chk("R6", busy_o, 0);
      chk("R5", bit_ready_o, 1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog: R6 stream stalled, actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk_i);
    chk("R7", line_o, 0);
    chk("R7", busy_o, 0);
    chk("R7", bit_ready_o, 1);
    rst_ni = 1'b1;
    rst_done = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1: period spacing of back-to-back ones
    rises.delete();
    for (int k = 0; k < 3; k++) send(1'b1, 3);
    drain();
    chk("R1", rises[1] - rises[0], 9);
    chk("R1", rises[2] - rises[1], 9);

    // R9: shortest period
    rises.delete();
    for (int k = 0; k < 3; k++) send(1'b1, 0);
    drain();
    chk("R9", rises[1] - rises[0], 6);

    // R9: longest period, zero then one, with extremes adjacent
    send(1'b1, 255);
    send(1'b0, 255);
    send(1'b1, 0);
    send(1'b1, 255);
    drain();

    // R2/R3/R4: odd and even periods, length switching each bit
    send(1'b1, 1);
    send(1'b1, 2);
    send(1'b0, 1);
    send(1'b1, 200);
    send(1'b1, 1);
    drain();

    // random streaming with gaps
    for (int k = 0; k < 400; k++) begin
      int blr;
      blr = ($urandom % 16 == 0) ? int'($urandom % 256) : int'($urandom % 12);
      send(1'($urandom), blr);
      if ($urandom % 6 == 0) idle(1 + int'($urandom % 20));
    end
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule